// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes an asynchronous serial line and turns it into parallel characters. A one-cycle clock-enable that pulses at sixteen times the baud rate paces it. A falling edge on the idle-high line starts a character. The receiver confirms that edge half a bit period later, then samples each data bit, the optional parity bit and the stop bit at the middle of its bit period. The data bits arrive least significant first.

The character length (five to eight bits), whether a parity bit is present, and whether parity is odd or even come from a static line-control input. Each finished character goes into a single read-only holding register. A five-bit status word reports, from bit 0 upward: data ready, overrun, parity error, framing error and break. The processor pulses one strobe when it takes the held character and another when it reads the status word.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the status word is 0, the held character is 0 and the receiver waits for a falling edge on an idle-high line.
- R2: If the line is back high at the eighth clock-enable after the falling edge, the edge is ignored. No character is produced and the status word does not change.
- R3: Each bit is sampled once every 16 clock-enables, at the middle of its bit period. The first data bit received becomes bit 0 of the held character.
- R4: The length code selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. The unused upper bits of the held character are 0.
- R5: Status bit 0 (data ready) is set when a character moves into the holding register. It is cleared by the data read strobe once the held character has been taken.
- R6: When parity is enabled, status bit 2 is set if the received parity bit is wrong. With even parity the data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number.
- R7: Status bit 3 (framing error) is set when the stop-bit sample is 0.
- R8: Status bit 4 (break) is set when every sample of the frame, from the start bit through the stop bit, is 0. A break also sets the framing error.
- R9: If a character completes while data ready is set and no data read happens in that cycle, status bit 1 (overrun) is set. The new character is dropped and the unread one is kept.
- R10: The status read strobe clears status bits 1 to 4 and leaves data ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick16 | input | 1 | Clock-enable at 16 times the baud rate |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| len_code | input | 2 | Data length: 0 gives 5 bits, 3 gives 8 bits |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_data_stb | input | 1 | Processor takes the held character |
| rd_stat_stb | input | 1 | Processor reads the status word |
| rx_data | output | 8 | Held character, zero-padded above its length |
| line_stat | output | 5 | Status: {break, framing, parity, overrun, ready} |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver that skipped the start-bit confirmation would build a bogus all-ones character there. It sends short characters with ones driven into the bit slots that follow the data. A design that did not zero-pad or align them would show those ones, or a shifted value, in the upper bits. It also sends a frame that is low throughout, a frame with a low stop bit, and frames with a wrong parity bit in both parity senses. Swapped status bits or a reversed parity sense then show up at once. Finally it lets two characters arrive without a read. A design that overwrote the buffer, or that let the status read clear data ready, would return the second byte or drop the ready flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_t;

  // number of data bits for a length code: MAXW-3 .. MAXW
  function automatic int unsigned char_bits(input logic [1:0] code, input int unsigned maxw);
    return maxw - 3 + int'(code);
  endfunction

  // right-shifted assembly leaves a short character in the top bits; move it down
  function automatic logic [7:0] align_char(input logic [7:0] sh, input logic [1:0] code);
    return sh >> (3 - int'(code));
  endfunction

  // parity bit the sender should have placed after the data
  function automatic logic parity_bit(input logic [7:0] data, input logic odd);
    return (^data) ^ odd;
  endfunction
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVERS  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_char,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_brk
);
  localparam int unsigned CNT_W = $clog2(OVERS);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERS/2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERS - 1);

  logic [SYNC_N-1:0] sync_q;
  logic              rxd_s;
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC_N-1];

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  nb;
  logic [DATA_W-1:0] sh;
  logic              armed, allz, par_q;
  logic [BIT_W-1:0]  last_bit;

  // named internal events for checking
  logic start_seen, start_ok, start_glitch, mid_pt;
  assign mid_pt       = tick16 && (cnt == CNT_LAST);
  assign start_seen   = tick16 && (state == ST_IDLE) && armed && !rxd_s;
  assign start_ok     = tick16 && (state == ST_START) && (cnt == CNT_MID) && !rxd_s;
  assign start_glitch = tick16 && (state == ST_START) && (cnt == CNT_MID) && rxd_s;
  assign last_bit     = BIT_W'(char_bits(len_code, DATA_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; nb <= '0; sh <= '0;
      armed <= 1'b0; allz <= 1'b0; par_q <= 1'b0;
      rx_done <= 1'b0; rx_char <= '0;
      rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_brk <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (tick16) begin
        unique case (state)
          ST_IDLE: begin
            if (!armed) armed <= rxd_s;
            else if (!rxd_s) begin
              state <= ST_START; cnt <= '0; armed <= 1'b0;
            end
          end
          ST_START: begin
            if (cnt == CNT_MID) begin
              cnt <= '0;
              if (rxd_s) state <= ST_IDLE;
              else begin
                state <= ST_DATA; nb <= '0; sh <= '0; allz <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            cnt <= cnt + 1'b1;
            if (mid_pt) begin
              sh   <= {rxd_s, sh[DATA_W-1:1]};
              allz <= allz & ~rxd_s;
              if (nb == last_bit) state <= par_en ? ST_PAR : ST_STOP;
              else                nb <= nb + 1'b1;
            end
          end
          ST_PAR: begin
            cnt <= cnt + 1'b1;
            if (mid_pt) begin
              par_q <= rxd_s; allz <= allz & ~rxd_s; state <= ST_STOP;
            end
          end
          ST_STOP: begin
            cnt <= cnt + 1'b1;
            if (mid_pt) begin
              rx_done <= 1'b1;
              rx_char <= align_char(sh, len_code);
              rx_perr <= par_en && (par_q != parity_bit(align_char(sh, len_code), par_odd));
              rx_ferr <= ~rxd_s;
              rx_brk  <= allz & ~rxd_s;
              state   <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch |=> (state == ST_IDLE) && !rx_done);
  p_start_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (state == ST_DATA) && (nb == '0));
  p_zero_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> ((rx_char >> char_bits(len_code, DATA_W)) == '0));
  p_break_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_brk) |-> rx_ferr);
  p_edge_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (state == ST_START));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rd_data_stb,
  input  logic              rd_stat_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic [4:0]        line_stat
);
  logic dr, oe, pe, fe, bi;
  logic load_ev, ovr_ev;
  assign ovr_ev  = rx_done && dr && !rd_data_stb;
  assign load_ev = rx_done && !ovr_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      {dr, oe, pe, fe, bi} <= '0;
    end else begin
      if (load_ev) begin
        rx_data <= rx_char; dr <= 1'b1;
      end else if (rd_data_stb) dr <= 1'b0;
      oe <= (oe & ~rd_stat_stb) | ovr_ev;
      pe <= (pe & ~rd_stat_stb) | (load_ev & rx_perr);
      fe <= (fe & ~rd_stat_stb) | (load_ev & rx_ferr);
      bi <= (bi & ~rd_stat_stb) | (load_ev & rx_brk);
    end
  end
  assign line_stat = {bi, fe, pe, oe, dr};

  p_ready_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !line_stat[0]) |=> line_stat[0]);
  p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && !rx_done) |=> !line_stat[0]);
  p_keep_unread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && line_stat[0] && !rd_data_stb) |=> ($stable(rx_data) && line_stat[1]));
  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_stb && !rx_done) |=> (line_stat[4:1] == 4'b0) && (line_stat[0] == $past(line_stat[0]) || $past(rd_data_stb)));
  p_break_with_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_stat[4] |-> line_stat[3]);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVERS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_data_stb,
  input  logic              rd_stat_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic [4:0]        line_stat
);
  logic              rx_done, rx_perr, rx_ferr, rx_brk;
  logic [DATA_W-1:0] rx_char;

  uart_rx_sampler #(.DATA_W(DATA_W), .OVERS(OVERS), .SYNC_N(2)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
    .rx_done(rx_done), .rx_char(rx_char), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_char(rx_char),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
    .rx_data(rx_data), .line_stat(line_stat)
  );
endmodule

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;
  localparam int DIV = 4;            // clocks per clock-enable
  localparam int BIT_CLKS = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] len_code = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, rd_data_stb = 1'b0, rd_stat_stb = 1'b0;
  logic [7:0] rx_data;
  logic [4:0] line_stat;

  always #2.5 clk = ~clk;

  int divcnt = 0;
  always @(posedge clk) begin
    divcnt <= (divcnt == DIV - 1) ? 0 : divcnt + 1;
    tick16 <= (divcnt == DIV - 1);
  end

  uart_rx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
    .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
    .rx_data(rx_data), .line_stat(line_stat)
  );

  typedef struct { logic [7:0] data; logic [4:0] stat; string req; } item_t;
  item_t sb_q[$];
  int checks = 0, fails = 0;
  bit auto_rd = 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // sends one frame and pushes what the receiver must report
  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_v,
                            input string req);
    int n;
    logic [7:0] exp_d;
    logic pbit;
    item_t it;
    n = 5 + int'(len_code);
    exp_d = d & 8'((1 << n) - 1);
    pbit = (^exp_d) ^ par_odd ^ bad_par;
    it.data = exp_d;
    it.stat = {1'b0, ~stop_v, par_en & bad_par, 1'b0, 1'b1};
    it.req  = req;
    sb_q.push_back(it);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) if (i < n) drive_bit(d[i]);
    if (par_en) drive_bit(pbit);
    drive_bit(stop_v);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  // monitor: pops the scoreboard whenever data ready is seen
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (auto_rd && line_stat[0]) begin
        if (sb_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 actual=unexpected char %0h expected=none", rx_data);
        end else begin
          it = sb_q.pop_front();
          check({it.req, " data"}, 32'(rx_data), 32'(it.data));
          check({it.req, " status"}, 32'(line_stat), 32'(it.stat));
        end
        rd_data_stb = 1'b1; rd_stat_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0; rd_stat_stb = 1'b0;
        check("R5/R10 cleared after reads", 32'(line_stat), 32'h0);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset status", 32'(line_stat), 32'h0);
    check("R1 reset data", 32'(rx_data), 32'h0);
    rst_n = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);

    // R3: 8 bits, no parity, LSB first
    send_frame(8'hA5, 1'b0, 1'b1, "R3");
    send_frame(8'h01, 1'b0, 1'b1, "R3");
    // R4: short characters; upper slots driven with ones
    len_code = 2'd0; send_frame(8'hF5, 1'b0, 1'b1, "R4");
    len_code = 2'd1; send_frame(8'hEA, 1'b0, 1'b1, "R4");
    len_code = 2'd2; send_frame(8'hFF, 1'b0, 1'b1, "R4");
    // R6: parity, both senses, good and bad
    len_code = 2'd3; par_en = 1'b1;
    par_odd = 1'b0; send_frame(8'h3C, 1'b0, 1'b1, "R6");
    par_odd = 1'b0; send_frame(8'h37, 1'b1, 1'b1, "R6");
    par_odd = 1'b1; send_frame(8'h81, 1'b0, 1'b1, "R6");
    par_odd = 1'b1; send_frame(8'h80, 1'b1, 1'b1, "R6");
    par_en = 1'b0; par_odd = 1'b0;
    // R7: low stop bit
    send_frame(8'h55, 1'b0, 1'b0, "R7");

    // R8: line low for a whole frame
    begin
      item_t it;
      it.data = 8'h00; it.stat = 5'b11001; it.req = "R8";
      sb_q.push_back(it);
      repeat (10) drive_bit(1'b0);
      repeat (3) drive_bit(1'b1);
    end

    // R2: low pulse of three clock-enables only
    rxd = 1'b0; repeat (3 * DIV) @(negedge clk);
    rxd = 1'b1; repeat (12 * BIT_CLKS) @(negedge clk);
    check("R2 glitch ignored", 32'(line_stat), 32'h0);
    check("R2 no pending item", 32'(sb_q.size()), 32'h0);

    // R9: two characters without a read
    auto_rd = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b1, "R9");
    send_frame(8'hC3, 1'b0, 1'b1, "R9");
    sb_q.delete();
    check("R9 unread byte kept", 32'(rx_data), 32'h5A);
    check("R9 overrun flagged", 32'(line_stat), 32'b00011);
    rd_stat_stb = 1'b1; @(negedge clk); rd_stat_stb = 1'b0;
    check("R10 errors cleared, ready kept", 32'(line_stat), 32'b00001);
    rd_data_stb = 1'b1; @(negedge clk); rd_data_stb = 1'b0;
    check("R5 ready cleared by data read", 32'(line_stat), 32'h0);
    auto_rd = 1'b1;
    send_frame(8'h96, 1'b0, 1'b1, "R3");
    repeat (BIT_CLKS) @(negedge clk);
    check("R3 scoreboard drained", 32'(sb_q.size()), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule